// File: doc/BRIEF.md
# Beam-Gated Video RAM Access Port

This block sits between a processor-facing register interface and a 64 KiB byte-addressed video memory. A 16-bit word address comes in from a programmable address register. One of four remap modes is applied to it. Then it is doubled to form the byte address. In modes 1 to 3, a low field of the address is rotated left by three bits.

Every processor read or write is gated by the current beam position (line and dot counters) and by four mode flags: display-disable, overscan, video region and interlace field. A blocked read returns 0x00. A blocked write never reaches memory. One dot on line 0 is special: a write there stores the processor's open-bus byte instead of its write data.

The block is a three-state machine:
- `ST_IDLE` is the rest state.
- `ST_RD_RESP` presents read data.
- `ST_WR_PULSE` drives the memory write strobe.

The state machine evaluates the same transitions from every state:
- A sampled `rd_req` moves it to `ST_RD_RESP`. This is the read-accept transition.
- An accepted write moves it to `ST_WR_PULSE`. This is the write-accept transition.
- Anything else, including a dropped write, moves it to `ST_IDLE`. This is the return transition.

Back-to-back requests therefore chain directly, with no idle cycle between them.

Top module: `vram_beam_port`

## Requirements
- R1: With `remap_mode`=0, the word address is not changed. `mem_raddr` equals the word address shifted left one bit, truncated to 16 bits (word 0x8001 gives byte 0x0002).
- R2: With `remap_mode`=k (k = 1, 2, 3), bits above 7+k are kept, and the low 7+k bits are rotated left by 3. Word 0x1234 gives byte addresses 0x2542, 0x2740 and 0x2348 for k = 1, 2, 3.
- R3: With `display_off`=1, every read returns memory data and every write stores `wr_data`, whatever the beam position.
- R4: With the display enabled, let V be 224 (`overscan`=0) or 239 (`overscan`=1).
  - Reads on lines below V return 0x00.
  - On line V, a read returns memory only at dot 1362. At every other dot it returns 0x00.
  - Lines above V read memory, except as R5 states.
- R5: With the display enabled, a read at dot 1362 of the last line returns 0x00.
  - The last line is 261 when `region_625`=0 and 311 when `region_625`=1.
  - One is added to it when `interlace`=1 and `field`=0.
- R6: With the display enabled, a write on line 0 behaves by dot:
  - dots 0 to 4 store `wr_data`;
  - dot 6 stores `open_bus`;
  - any other dot is dropped.
- R7: With the display enabled, writes behave by line:
  - lines 1 to V are dropped;
  - on line V+1, dots 0 to 4 are dropped and later dots are stored;
  - lines above V+1 store `wr_data`.
- R8: `rd_valid` is high for one clock, one clock after `rd_req` is sampled, and `rd_data` is valid with it. `rd_data` holds its value while no read is served.
- R9: Each accepted write raises `mem_we` for exactly one clock, one clock after `wr_req`, with `mem_waddr` and `mem_wdata`. A dropped write never raises `mem_we`.
- R10: When `rd_req` and `wr_req` are high in the same cycle, the read is served and the write is ignored.
- R11: After reset, `rd_valid`=0, `mem_we`=0 and `rd_data`=0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_addr | input | 16 | Word address from the address register |
| remap_mode | input | 2 | Address remap mode 0..3 |
| rd_req | input | 1 | Read request, one cycle |
| wr_req | input | 1 | Write request, one cycle |
| wr_data | input | 8 | Processor write byte |
| open_bus | input | 8 | Processor open-bus byte |
| line | input | 9 | Current beam line |
| dot | input | 11 | Current beam dot |
| display_off | input | 1 | Display disabled: access always allowed |
| overscan | input | 1 | Overscan mode (visible area ends at 239) |
| region_625 | input | 1 | 625-line region when 1, 525-line region when 0 |
| interlace | input | 1 | Interlace enabled |
| field | input | 1 | Current interlace field |
| mem_rdata | input | 8 | Memory read byte for `mem_raddr` (asynchronous) |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | Read result valid |
| mem_raddr | output | 16 | Byte address for the current word address |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | 16 | Registered write byte address |
| mem_wdata | output | 8 | Registered write byte |

## Verification
`mem_raddr` is combinational, so the bench compares it in the same cycle the request is driven. `rd_valid`, `rd_data`, `mem_we`, `mem_waddr` and `mem_wdata` each pass through one register, so their results are due exactly one clock after the request edge. Inputs change on falling edges. Each result is compared at the falling edge after the rising edge that captured the request. One further falling edge later, the bench confirms that `rd_valid` and `mem_we` have dropped, which shows the strobe lasted a single clock.

// File: rtl/vbp_pkg.sv
package vbp_pkg;
    typedef enum logic [1:0] {
        MAP_LINEAR = 2'd0,
        MAP_ROT8   = 2'd1,
        MAP_ROT9   = 2'd2,
        MAP_ROT10  = 2'd3
    } remap_e;

    typedef enum logic [1:0] {
        WR_DROP = 2'd0,
        WR_CPU  = 2'd1,
        WR_BUS  = 2'd2
    } wr_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RD_RESP  = 2'd1,
        ST_WR_PULSE = 2'd2
    } port_state_e;
endpackage

// File: rtl/vbp_remap.sv
module vbp_remap #(
    parameter int AW     = 16,
    parameter int MODES  = 4,
    parameter int BASE_W = 8,
    parameter int ROT    = 3,
    localparam int MW    = $clog2(MODES)
) (
    input  logic [AW-1:0] word_addr,
    input  logic [MW-1:0] mode,
    output logic [AW-1:0] byte_addr
);
    logic [MODES-1:0][AW-1:0] cand;

    assign cand[0] = word_addr;

    // Mode k rotates the low BASE_W-1+k bits left by ROT.
    generate
        for (genvar k = 1; k < MODES; k++) begin : g_rot
            localparam int FW = BASE_W - 1 + k;
            assign cand[k] = {word_addr[AW-1:FW],
                              word_addr[FW-ROT-1:0],
                              word_addr[FW-1:FW-ROT]};
        end
    endgenerate

    assign byte_addr = cand[mode] << 1;

    // R1: linear mode reaches the output only through the doubling
    always_comb begin
        if (!$isunknown({mode, word_addr}) && mode == '0) begin
            assert_linear_map_R1: assert (byte_addr == {word_addr[AW-2:0], 1'b0})
                else $error("linear map broken");
        end
    end
endmodule

// File: rtl/vbp_gate.sv
module vbp_gate
    import vbp_pkg::*;
#(
    parameter int LINE_W   = 9,
    parameter int DOT_W    = 11,
    parameter int VIS_STD  = 224,
    parameter int VIS_OS   = 239,
    parameter int LAST_STD = 261,
    parameter int LAST_ALT = 311,
    parameter int EDGE_DOT = 1362,
    parameter int EARLY_DOT = 4,
    parameter int BUS_DOT  = 6
) (
    input  logic [LINE_W-1:0] line,
    input  logic [DOT_W-1:0]  dot,
    input  logic              display_off,
    input  logic              overscan,
    input  logic              region_625,
    input  logic              interlace,
    input  logic              field,
    output logic              rd_ok,
    output wr_sel_e           wr_sel
);
    localparam logic [LINE_W-1:0] VIS_STD_L  = LINE_W'(VIS_STD);
    localparam logic [LINE_W-1:0] VIS_OS_L   = LINE_W'(VIS_OS);
    localparam logic [LINE_W-1:0] LAST_STD_L = LINE_W'(LAST_STD);
    localparam logic [LINE_W-1:0] LAST_ALT_L = LINE_W'(LAST_ALT);
    localparam logic [DOT_W-1:0]  EDGE_L     = DOT_W'(EDGE_DOT);
    localparam logic [DOT_W-1:0]  EARLY_L    = DOT_W'(EARLY_DOT);
    localparam logic [DOT_W-1:0]  BUS_L      = DOT_W'(BUS_DOT);

    logic [LINE_W-1:0] vis_line;
    logic [LINE_W-1:0] wr_edge_line;
    logic [LINE_W-1:0] last_line;
    logic              at_edge_dot;
    logic              early_dot;

    assign vis_line     = overscan ? VIS_OS_L : VIS_STD_L;
    assign wr_edge_line = vis_line + LINE_W'(1);
    assign last_line    = (region_625 ? LAST_ALT_L : LAST_STD_L)
                        + LINE_W'(interlace & ~field);
    assign at_edge_dot  = (dot == EDGE_L);
    assign early_dot    = (dot <= EARLY_L);

    // Read window
    always_comb begin
        if (display_off)                          rd_ok = 1'b1;
        else if (line == last_line && at_edge_dot) rd_ok = 1'b0;
        else if (line < vis_line)                 rd_ok = 1'b0;
        else if (line == vis_line)                rd_ok = at_edge_dot;
        else                                      rd_ok = 1'b1;
    end

    // Write window
    always_comb begin
        if (display_off) begin
            wr_sel = WR_CPU;
        end else if (line == '0) begin
            if (early_dot)        wr_sel = WR_CPU;
            else if (dot == BUS_L) wr_sel = WR_BUS;
            else                  wr_sel = WR_DROP;
        end else if (line < wr_edge_line) begin
            wr_sel = WR_DROP;
        end else if (line == wr_edge_line) begin
            wr_sel = early_dot ? WR_DROP : WR_CPU;
        end else begin
            wr_sel = WR_CPU;
        end
    end

    // R7: nothing is stored inside the active picture
    always_comb begin
        if (!$isunknown({display_off, line, overscan}) && !display_off
            && line != '0 && line <= vis_line) begin
            assert_mid_frame_drop_R7: assert (wr_sel == WR_DROP)
                else $error("write leaked into active lines");
        end
    end

    // R3: a disabled display opens both paths
    always_comb begin
        if (!$isunknown(display_off) && display_off) begin
            assert_blank_open_R3: assert (rd_ok && wr_sel == WR_CPU)
                else $error("access blocked with display off");
        end
    end
endmodule

// File: rtl/vram_beam_port.sv
module vram_beam_port
    import vbp_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 8,
    parameter int LINE_W = 9,
    parameter int DOT_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     word_addr,
    input  logic [1:0]        remap_mode,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [DW-1:0]     wr_data,
    input  logic [DW-1:0]     open_bus,
    input  logic [LINE_W-1:0] line,
    input  logic [DOT_W-1:0]  dot,
    input  logic              display_off,
    input  logic              overscan,
    input  logic              region_625,
    input  logic              interlace,
    input  logic              field,
    input  logic [DW-1:0]     mem_rdata,
    output logic [DW-1:0]     rd_data,
    output logic              rd_valid,
    output logic [AW-1:0]     mem_raddr,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic [DW-1:0]     mem_wdata
);
    logic [AW-1:0] byte_addr;
    logic          rd_ok;
    wr_sel_e       wr_sel;
    logic          wr_take;
    port_state_e   state_q, state_d, accept_next;

    vbp_remap #(.AW(AW), .MODES(4)) u_remap (
        .word_addr (word_addr),
        .mode      (remap_mode),
        .byte_addr (byte_addr)
    );

    vbp_gate #(.LINE_W(LINE_W), .DOT_W(DOT_W)) u_gate (
        .line        (line),
        .dot         (dot),
        .display_off (display_off),
        .overscan    (overscan),
        .region_625  (region_625),
        .interlace   (interlace),
        .field       (field),
        .rd_ok       (rd_ok),
        .wr_sel      (wr_sel)
    );

    assign mem_raddr = byte_addr;
    assign wr_take   = wr_req && !rd_req && (wr_sel != WR_DROP);

    // Next state: read beats write, dropped writes return to idle
    always_comb begin
        if (rd_req)       accept_next = ST_RD_RESP;
        else if (wr_take) accept_next = ST_WR_PULSE;
        else              accept_next = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_RD_RESP, ST_WR_PULSE: state_d = accept_next;
            default:                          state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data   <= '0;
            mem_waddr <= '0;
            mem_wdata <= '0;
        end else if (rd_req) begin
            rd_data <= rd_ok ? mem_rdata : '0;
        end else if (wr_take) begin
            mem_waddr <= byte_addr;
            mem_wdata <= (wr_sel == WR_BUS) ? open_bus : wr_data;
        end
    end

    assign rd_valid = (state_q == ST_RD_RESP);
    assign mem_we   = (state_q == ST_WR_PULSE);

    assert_rd_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));

    assert_we_follows_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(wr_req) && !$past(rd_req)));

    assert_read_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && wr_req) |=> (rd_valid && !mem_we));

    assert_blocked_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ok) |=> (rd_data == '0));

    assert_bus_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !rd_req && !display_off && line == '0 && dot == DOT_W'(6))
        |=> (mem_we && mem_wdata == $past(open_bus)));

    assert_blank_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !rd_req && display_off) |=> (mem_we && mem_wdata == $past(wr_data)));
endmodule

// File: tb/test_vram_beam_port.sv
`timescale 1ns/1ps
module test_vram_beam_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] word_addr = '0;
    logic [1:0]  remap_mode = '0;
    logic        rd_req = 1'b0, wr_req = 1'b0;
    logic [7:0]  wr_data = 8'hC3, open_bus = 8'h3C;
    logic [8:0]  line = '0;
    logic [10:0] dot = '0;
    logic        display_off = 1'b0, overscan = 1'b0, region_625 = 1'b0;
    logic        interlace = 1'b0, field = 1'b0;
    logic [7:0]  mem_rdata;
    logic [7:0]  rd_data;
    logic        rd_valid, mem_we;
    logic [15:0] mem_raddr, mem_waddr;
    logic [7:0]  mem_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [7:0] model(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    assign mem_rdata = model(mem_raddr);

    vram_beam_port i_vram_beam_port (
        .clk(clk), .rst_n(rst_n), .word_addr(word_addr), .remap_mode(remap_mode),
        .rd_req(rd_req), .wr_req(wr_req), .wr_data(wr_data), .open_bus(open_bus),
        .line(line), .dot(dot), .display_off(display_off), .overscan(overscan),
        .region_625(region_625), .interlace(interlace), .field(field),
        .mem_rdata(mem_rdata), .rd_data(rd_data), .rd_valid(rd_valid),
        .mem_raddr(mem_raddr), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // kind: read 0 = 0x00, 1 = memory; write 0 = dropped, 1 = wr_data, 2 = open_bus
    typedef struct packed {
        logic [3:0]  req;
        logic        wr;
        logic [1:0]  mode;
        logic [15:0] addr;
        logic [8:0]  ln;
        logic [10:0] dt;
        logic        doff, os, r625, il, fld;
        logic [1:0]  kind;
        logic [15:0] baddr;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VECS [NV] = '{
        // R3 display off
        '{4'd3, 1'b0, 2'd0, 16'h1234, 9'd10,  11'd100,  1'b1,1'b0,1'b0,1'b0,1'b0, 2'd1, 16'h2468},
        '{4'd3, 1'b1, 2'd0, 16'h1234, 9'd100, 11'd100,  1'b1,1'b0,1'b0,1'b0,1'b0, 2'd1, 16'h2468},
        // R1 / R2 remap modes
        '{4'd1, 1'b0, 2'd0, 16'h1234, 9'd10,  11'd0,    1'b1,1'b0,1'b0,1'b0,1'b0, 2'd1, 16'h2468},
        '{4'd2, 1'b0, 2'd1, 16'h1234, 9'd10,  11'd0,    1'b1,1'b0,1'b0,1'b0,1'b0, 2'd1, 16'h2542},
        '{4'd2, 1'b0, 2'd2, 16'h1234, 9'd10,  11'd0,    1'b1,1'b0,1'b0,1'b0,1'b0, 2'd1, 16'h2740},
        '{4'd2, 1'b0, 2'd3, 16'h1234, 9'd10,  11'd0,    1'b1,1'b0,1'b0,1'b0,1'b0, 2'd1, 16'h2348},
        // R4 read window
        '{4'd4, 1'b0, 2'd0, 16'h1234, 9'd100, 11'd100,  1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0, 16'h2468},
        '{4'd4, 1'b0, 2'd0, 16'h1234, 9'd223, 11'd1362, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0, 16'h2468},
        '{4'd4, 1'b0, 2'd0, 16'h1234, 9'd224, 11'd1362, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd1, 16'h2468},
        '{4'd4, 1'b0, 2'd0, 16'h1234, 9'd224, 11'd1361, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0, 16'h2468},
        '{4'd4, 1'b0, 2'd0, 16'h1234, 9'd225, 11'd0,    1'b0,1'b0,1'b0,1'b0,1'b0, 2'd1, 16'h2468},
        '{4'd4, 1'b0, 2'd0, 16'h1234, 9'd238, 11'd1362, 1'b0,1'b1,1'b0,1'b0,1'b0, 2'd0, 16'h2468},
        '{4'd4, 1'b0, 2'd0, 16'h1234, 9'd239, 11'd1362, 1'b0,1'b1,1'b0,1'b0,1'b0, 2'd1, 16'h2468},
        '{4'd4, 1'b0, 2'd0, 16'h1234, 9'd239, 11'd5,    1'b0,1'b1,1'b0,1'b0,1'b0, 2'd0, 16'h2468},
        '{4'd4, 1'b0, 2'd0, 16'h1234, 9'd240, 11'd0,    1'b0,1'b1,1'b0,1'b0,1'b0, 2'd1, 16'h2468},
        // R5 last line edge dot
        '{4'd5, 1'b0, 2'd0, 16'h1234, 9'd261, 11'd1362, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0, 16'h2468},
        '{4'd5, 1'b0, 2'd0, 16'h1234, 9'd261, 11'd1361, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd1, 16'h2468},
        '{4'd5, 1'b0, 2'd0, 16'h1234, 9'd311, 11'd1362, 1'b0,1'b0,1'b1,1'b0,1'b0, 2'd0, 16'h2468},
        '{4'd5, 1'b0, 2'd0, 16'h1234, 9'd261, 11'd1362, 1'b0,1'b0,1'b1,1'b0,1'b0, 2'd1, 16'h2468},
        '{4'd5, 1'b0, 2'd0, 16'h1234, 9'd262, 11'd1362, 1'b0,1'b0,1'b0,1'b1,1'b0, 2'd0, 16'h2468},
        '{4'd5, 1'b0, 2'd0, 16'h1234, 9'd261, 11'd1362, 1'b0,1'b0,1'b0,1'b1,1'b0, 2'd1, 16'h2468},
        '{4'd5, 1'b0, 2'd0, 16'h1234, 9'd261, 11'd1362, 1'b0,1'b0,1'b0,1'b1,1'b1, 2'd0, 16'h2468},
        // R6 line 0 writes
        '{4'd6, 1'b1, 2'd0, 16'h1234, 9'd0,   11'd0,    1'b0,1'b0,1'b0,1'b0,1'b0, 2'd1, 16'h2468},
        '{4'd6, 1'b1, 2'd0, 16'h1234, 9'd0,   11'd4,    1'b0,1'b0,1'b0,1'b0,1'b0, 2'd1, 16'h2468},
        '{4'd6, 1'b1, 2'd0, 16'h1234, 9'd0,   11'd5,    1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0, 16'h2468},
        '{4'd6, 1'b1, 2'd0, 16'h1234, 9'd0,   11'd6,    1'b0,1'b0,1'b0,1'b0,1'b0, 2'd2, 16'h2468},
        '{4'd6, 1'b1, 2'd0, 16'h1234, 9'd0,   11'd7,    1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0, 16'h2468},
        // R7 write window
        '{4'd7, 1'b1, 2'd0, 16'h1234, 9'd1,   11'd100,  1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0, 16'h2468},
        '{4'd7, 1'b1, 2'd0, 16'h1234, 9'd224, 11'd100,  1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0, 16'h2468},
        '{4'd7, 1'b1, 2'd0, 16'h1234, 9'd225, 11'd4,    1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0, 16'h2468},
        '{4'd7, 1'b1, 2'd0, 16'h1234, 9'd225, 11'd5,    1'b0,1'b0,1'b0,1'b0,1'b0, 2'd1, 16'h2468},
        '{4'd7, 1'b1, 2'd0, 16'h1234, 9'd300, 11'd0,    1'b0,1'b0,1'b0,1'b0,1'b0, 2'd1, 16'h2468},
        '{4'd7, 1'b1, 2'd0, 16'h1234, 9'd239, 11'd100,  1'b0,1'b1,1'b0,1'b0,1'b0, 2'd0, 16'h2468},
        '{4'd7, 1'b1, 2'd0, 16'h1234, 9'd240, 11'd4,    1'b0,1'b1,1'b0,1'b0,1'b0, 2'd0, 16'h2468},
        '{4'd7, 1'b1, 2'd0, 16'h1234, 9'd240, 11'd5,    1'b0,1'b1,1'b0,1'b0,1'b0, 2'd1, 16'h2468}
    };

    task automatic run_vec(input vec_t v);
        string tag;
        tag = $sformatf("R%0d", v.req);
        @(negedge clk);
        word_addr = v.addr; remap_mode = v.mode; line = v.ln; dot = v.dt;
        display_off = v.doff; overscan = v.os; region_625 = v.r625;
        interlace = v.il; field = v.fld;
        rd_req = !v.wr; wr_req = v.wr;
        #0.5;
        if (!v.wr) check(mem_raddr == v.baddr, {tag, " read address"}, mem_raddr, v.baddr);
        @(negedge clk);
        rd_req = 1'b0; wr_req = 1'b0;
        if (!v.wr) begin
            check(rd_valid == 1'b1, {tag, " rd_valid (R8)"}, rd_valid, 1);
            check(rd_data == (v.kind != 0 ? model(v.baddr) : 8'h00),
                  {tag, " read data"}, rd_data, (v.kind != 0 ? model(v.baddr) : 8'h00));
        end else if (v.kind == 0) begin
            check(mem_we == 1'b0, {tag, " dropped write strobe"}, mem_we, 0);
        end else begin
            check(mem_we == 1'b1, {tag, " write strobe (R9)"}, mem_we, 1);
            check(mem_waddr == v.baddr, {tag, " write address"}, mem_waddr, v.baddr);
            check(mem_wdata == (v.kind == 2 ? open_bus : wr_data), {tag, " write data"},
                  mem_wdata, (v.kind == 2 ? open_bus : wr_data));
        end
        @(negedge clk);
        check(mem_we == 1'b0 && rd_valid == 1'b0, {tag, " single pulse (R8/R9)"},
              {mem_we, rd_valid}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(rd_valid == 1'b0, "R11 rd_valid in reset", rd_valid, 0);
        check(mem_we == 1'b0, "R11 mem_we in reset", mem_we, 0);
        check(rd_data == 8'h00, "R11 rd_data in reset", rd_data, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R1 top bit falls off in the doubling
        @(negedge clk);
        display_off = 1'b1; remap_mode = 2'd0; word_addr = 16'h8001; #0.5;
        check(mem_raddr == 16'h0002, "R1 truncation", mem_raddr, 16'h0002);

        // R10 read beats write in the same cycle
        @(negedge clk);
        display_off = 1'b0; line = 9'd300; dot = 11'd10; word_addr = 16'h1234;
        rd_req = 1'b1; wr_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0; wr_req = 1'b0;
        check(rd_valid == 1'b1 && mem_we == 1'b0, "R10 read served, write ignored",
              {rd_valid, mem_we}, 2'b10);
        check(rd_data == model(16'h2468), "R10 read data", rd_data, model(16'h2468));

        // R8 rd_data holds while idle
        @(negedge clk);
        check(rd_valid == 1'b0 && rd_data == model(16'h2468), "R8 hold",
              {rd_valid, rd_data}, {1'b0, model(16'h2468)});

        // R9 back-to-back writes give two consecutive strobes then stop
        @(negedge clk);
        wr_req = 1'b1; wr_data = 8'h11;
        @(negedge clk);
        wr_data = 8'h22;
        check(mem_we == 1'b1 && mem_wdata == 8'h11, "R9 first of pair",
              {mem_we, mem_wdata}, {1'b1, 8'h11});
        @(negedge clk);
        wr_req = 1'b0;
        check(mem_we == 1'b1 && mem_wdata == 8'h22, "R9 second of pair",
              {mem_we, mem_wdata}, {1'b1, 8'h22});
        @(negedge clk);
        check(mem_we == 1'b0, "R9 strobe ends", mem_we, 0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule